// File: doc/BRIEF.md
# Power Table with Auto-Index

This block holds an eight-entry table of amplifier power settings behind a byte-serial register interface. A host drives chip select low, sends a header byte, and then moves data bytes into or out of the table. The block keeps no address per byte. An internal index picks the entry for every data byte, steps by one after each transfer, and wraps from the last entry back to entry 0. The index returns to 0 whenever chip select is high.

The header chooses the transfer direction and chooses between single-byte and burst access. A single access moves one data byte and then expects a new header. The index keeps its value after a single access, so a later single access in the same chip-select window uses the next entry. A burst access carries on until chip select rises. A 3-bit power select input picks which entry drives the amplifier setting output at all times. A sleep request clears every entry except entry 0.

Top module: `pt_power_table`

## Requirements
- R1: After reset every entry is 0x00, the index is 0, `rd_valid` is low and `pa_setting` is 0x00 for every `pwr_sel` value.
- R2: The first byte after chip select falls is a header. The table is selected when header bits [5:0] equal 0x3E. Bit 7 is the direction (0 = write, 1 = read) and bit 6 chooses burst (1) or single (0). The four table headers are 0x3E, 0x7E, 0xBE and 0xFE.
- R3: A write data byte is stored in the entry that the index selects, and the index then increments.
- R4: A read data byte returns the selected entry on `rd_data`, with `rd_valid` high for one cycle in the cycle after the byte. The index then increments.
- R5: The index wraps from 7 to 0 and does not stop, in burst reads and in burst writes alike.
- R6: While `cs_n` is high the index is held at 0, the next byte is taken as a header, and any byte strobes are ignored.
- R7: After one data byte of a single access, the next byte is decoded as a header. The index is not reset, so a single read that follows a single write in the same window returns the next entry.
- R8: `pa_setting` always shows the entry that `pwr_sel` selects. It follows a change of `pwr_sel` in the same cycle.
- R9: A `sleep_req` pulse sets entries 1 to 7 to 0x00 and leaves entry 0 unchanged.
- R10: After a header whose bits [5:0] are not 0x3E, all bytes are ignored until `cs_n` goes high. They cause no write and no read.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous reset, active low |
| cs_n | input | 1 | Chip select, active low |
| byte_valid | input | 1 | One-cycle strobe marking a received byte |
| byte_in | input | 8 | Received byte (header or data) |
| rd_data | output | 8 | Entry returned for a read data byte |
| rd_valid | output | 1 | High for one cycle when `rd_data` is new |
| pwr_sel | input | 3 | Power select that chooses the active entry |
| sleep_req | input | 1 | One-cycle pulse for entering sleep |
| pa_setting | output | 8 | Amplifier control byte from the selected entry |

## Verification
The assertions assume three things about the inputs. `byte_valid` is a single-cycle strobe for each byte. `sleep_req` never arrives in the same cycle as a data byte. Chip select stays high for at least one full clock cycle between transfers. The stimulus meets all three. It drives every input on the falling edge, holds each strobe for exactly one cycle, and issues sleep only while chip select is high. It also raises a byte strobe while chip select is high, to exercise the ignore rule. No assertion depends on that case.

// File: rtl/pt_pkg.sv
package pt_pkg;

    localparam int HDR_W = 8;

    typedef enum logic [1:0] {
        PH_HDR  = 2'd0,
        PH_DATA = 2'd1,
        PH_SKIP = 2'd2
    } phase_e;

    typedef struct packed {
        phase_e ph;
        logic   rw;
        logic   burst;
    } seq_t;

endpackage

// File: rtl/pt_hdr_decode.sv
module pt_hdr_decode
    import pt_pkg::*;
#(
    parameter int            ADDR_W     = 6,
    parameter logic [5:0]    TABLE_ADDR = 6'h3E
) (
    input  logic [HDR_W-1:0] hdr,
    output logic             hit,
    output logic             rw,
    output logic             burst
);

    localparam int RW_BIT    = HDR_W - 1;
    localparam int BURST_BIT = HDR_W - 2;

    always_comb begin
        hit   = (hdr[ADDR_W-1:0] == TABLE_ADDR[ADDR_W-1:0]);
        rw    = hdr[RW_BIT];
        burst = hdr[BURST_BIT];
    end

endmodule

// File: rtl/pt_seq.sv
module pt_seq
    import pt_pkg::*;
(
    input  logic clk,
    input  logic rst_n,
    input  logic cs_n,
    input  logic byte_valid,
    input  logic hdr_hit,
    input  logic hdr_rw,
    input  logic hdr_burst,
    output logic wr_stb,
    output logic rd_stb
);

    seq_t seq_d, seq_q;

    always_comb begin
        seq_d  = seq_q;
        wr_stb = 1'b0;
        rd_stb = 1'b0;
        if (cs_n) begin
            seq_d.ph = PH_HDR;
        end else if (byte_valid) begin
            unique case (seq_q.ph)
                PH_HDR: begin
                    if (hdr_hit) begin
                        seq_d.ph    = PH_DATA;
                        seq_d.rw    = hdr_rw;
                        seq_d.burst = hdr_burst;
                    end else begin
                        seq_d.ph = PH_SKIP;
                    end
                end
                PH_DATA: begin
                    rd_stb = seq_q.rw;
                    wr_stb = ~seq_q.rw;
                    if (!seq_q.burst) begin
                        seq_d.ph = PH_HDR;
                    end
                end
                default: begin
                    seq_d.ph = PH_SKIP;
                end
            endcase
        end
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            seq_q <= '{ph: PH_HDR, rw: 1'b0, burst: 1'b0};
        end else begin
            seq_q <= seq_d;
        end
    end

    AST_SKIP_HOLDS: assert property (@(posedge clk) disable iff (!rst_n) // R10
        (seq_q.ph == PH_SKIP && !cs_n) |=> (seq_q.ph == PH_SKIP));

    AST_SINGLE_RETURNS: assert property (@(posedge clk) disable iff (!rst_n) // R7
        (seq_q.ph == PH_DATA && !seq_q.burst && byte_valid && !cs_n) |=> (seq_q.ph == PH_HDR));

    AST_CS_HIGH_HDR: assert property (@(posedge clk) disable iff (!rst_n) // R6
        cs_n |=> (seq_q.ph == PH_HDR));

endmodule

// File: rtl/pt_index.sv
module pt_index #(
    parameter int DEPTH = 8,
    localparam int IDX_W = $clog2(DEPTH)
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic             cs_n,
    input  logic             step,
    output logic [IDX_W-1:0] idx
);

    localparam logic [IDX_W-1:0] IDX_LAST = IDX_W'(DEPTH - 1);

    logic [IDX_W-1:0] idx_d, idx_q;

    always_comb begin
        idx_d = idx_q;
        if (cs_n) begin
            idx_d = '0;
        end else if (step) begin
            idx_d = (idx_q == IDX_LAST) ? '0 : idx_q + 1'b1;
        end
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            idx_q <= '0;
        end else begin
            idx_q <= idx_d;
        end
    end

    assign idx = idx_q;

    AST_IDX_ZERO_CS: assert property (@(posedge clk) disable iff (!rst_n) // R6
        cs_n |=> (idx_q == '0));

    AST_IDX_WRAP: assert property (@(posedge clk) disable iff (!rst_n) // R5
        (!cs_n && step && idx_q == IDX_LAST) |=> (idx_q == '0));

    AST_IDX_STEP: assert property (@(posedge clk) disable iff (!rst_n) // R3
        (!cs_n && step && idx_q != IDX_LAST) |=> (idx_q == $past(idx_q) + 1'b1));

    AST_IDX_HOLD: assert property (@(posedge clk) disable iff (!rst_n) // R7
        (!cs_n && !step) |=> $stable(idx_q));

endmodule

// File: rtl/pt_store.sv
module pt_store #(
    parameter int DEPTH = 8,
    parameter int W     = 8,
    localparam int IDX_W = $clog2(DEPTH)
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic             wr_en,
    input  logic [IDX_W-1:0] idx,
    input  logic [W-1:0]     wr_data,
    input  logic             sleep,
    input  logic [IDX_W-1:0] sel,
    output logic [W-1:0]     acc_data,
    output logic [W-1:0]     sel_data
);

    logic [DEPTH-1:0][W-1:0] tbl_d, tbl_q;

    always_comb begin
        tbl_d = tbl_q;
        if (sleep) begin
            for (int i = 1; i < DEPTH; i++) begin
                tbl_d[i] = '0;
            end
        end else if (wr_en) begin
            tbl_d[idx] = wr_data;
        end
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            tbl_q <= '0;
        end else begin
            tbl_q <= tbl_d;
        end
    end

    assign acc_data = tbl_q[idx];
    assign sel_data = tbl_q[sel];

    AST_SLEEP_KEEP0: assert property (@(posedge clk) disable iff (!rst_n) // R9
        sleep |=> (tbl_q[0] == $past(tbl_q[0])));

    AST_SLEEP_CLEAR: assert property (@(posedge clk) disable iff (!rst_n) // R9
        sleep |=> (tbl_q[DEPTH-1:1] == '0));

    AST_WRITE_LANDS: assert property (@(posedge clk) disable iff (!rst_n) // R3
        (wr_en && !sleep) |=> (tbl_q[$past(idx)] == $past(wr_data)));

endmodule

// File: rtl/pt_power_table.sv
module pt_power_table
    import pt_pkg::*;
#(
    parameter int         DEPTH      = 8,
    parameter int         W          = 8,
    parameter int         ADDR_W     = 6,
    parameter logic [5:0] TABLE_ADDR = 6'h3E,
    localparam int        IDX_W      = $clog2(DEPTH)
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic             cs_n,
    input  logic             byte_valid,
    input  logic [HDR_W-1:0] byte_in,
    output logic [W-1:0]     rd_data,
    output logic             rd_valid,
    input  logic [IDX_W-1:0] pwr_sel,
    input  logic             sleep_req,
    output logic [W-1:0]     pa_setting
);

    typedef struct packed {
        logic [W-1:0] rd_data;
        logic         rd_valid;
    } out_t;

    logic             hdr_hit, hdr_rw, hdr_burst;
    logic             wr_stb, rd_stb, step;
    logic [IDX_W-1:0] idx;
    logic [W-1:0]     acc_data;
    out_t             out_d, out_q;

    pt_hdr_decode #(.ADDR_W(ADDR_W), .TABLE_ADDR(TABLE_ADDR)) u_dec (
        .hdr   (byte_in),
        .hit   (hdr_hit),
        .rw    (hdr_rw),
        .burst (hdr_burst)
    );

    pt_seq u_seq (
        .clk        (clk),
        .rst_n      (rst_n),
        .cs_n       (cs_n),
        .byte_valid (byte_valid),
        .hdr_hit    (hdr_hit),
        .hdr_rw     (hdr_rw),
        .hdr_burst  (hdr_burst),
        .wr_stb     (wr_stb),
        .rd_stb     (rd_stb)
    );

    assign step = wr_stb | rd_stb;

    pt_index #(.DEPTH(DEPTH)) u_idx (
        .clk   (clk),
        .rst_n (rst_n),
        .cs_n  (cs_n),
        .step  (step),
        .idx   (idx)
    );

    pt_store #(.DEPTH(DEPTH), .W(W)) u_store (
        .clk      (clk),
        .rst_n    (rst_n),
        .wr_en    (wr_stb),
        .idx      (idx),
        .wr_data  (byte_in[W-1:0]),
        .sleep    (sleep_req),
        .sel      (pwr_sel),
        .acc_data (acc_data),
        .sel_data (pa_setting)
    );

    always_comb begin
        out_d          = out_q;
        out_d.rd_valid = rd_stb;
        if (rd_stb) begin
            out_d.rd_data = acc_data;
        end
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            out_q <= '0;
        end else begin
            out_q <= out_d;
        end
    end

    assign rd_data  = out_q.rd_data;
    assign rd_valid = out_q.rd_valid;

    AST_RDV_NEEDS_CS: assert property (@(posedge clk) disable iff (!rst_n) // R4
        rd_valid |-> $past(!cs_n && byte_valid));

    AST_RDV_PULSE: assert property (@(posedge clk) disable iff (!rst_n) // R4
        (rd_valid && !$past(rd_valid)) |=> (!rd_valid || $past(rd_stb)));

    AST_IDLE_NO_CHANGE: assert property (@(posedge clk) disable iff (!rst_n) // R6
        (cs_n && !sleep_req) |=> ($stable(pwr_sel) -> $stable(pa_setting)));

    AST_NO_RDV_CS_HIGH: assert property (@(posedge clk) disable iff (!rst_n) // R6
        cs_n |=> !rd_valid);

endmodule

// File: tb/sim_pt_power_table.sv
module sim_pt_power_table;

    localparam int CLK_PERIOD = 10;

    logic       clk = 1'b0;
    logic       rst_n = 1'b0;
    logic       cs_n = 1'b1;
    logic       byte_valid = 1'b0;
    logic [7:0] byte_in = '0;
    logic [7:0] rd_data;
    logic       rd_valid;
    logic [2:0] pwr_sel = '0;
    logic       sleep_req = 1'b0;
    logic [7:0] pa_setting;

    int n_cmp = 0;
    int n_bad = 0;

    logic [7:0] m_tbl [8];
    int         m_idx = 0;
    logic [7:0] exp_q [$];
    string      tag_q [$];

    always #(CLK_PERIOD/2) clk = ~clk;

    pt_power_table u0 (
        .clk        (clk),
        .rst_n      (rst_n),
        .cs_n       (cs_n),
        .byte_valid (byte_valid),
        .byte_in    (byte_in),
        .rd_data    (rd_data),
        .rd_valid   (rd_valid),
        .pwr_sel    (pwr_sel),
        .sleep_req  (sleep_req),
        .pa_setting (pa_setting)
    );

    task automatic report(input string tag, input logic [7:0] act, input logic [7:0] exp);
        n_cmp++;
        if (act !== exp) begin
            n_bad++;
            $display("FAIL %s: actual %02h expected %02h", tag, act, exp);
        end
    endtask

    // monitor: pops the scoreboard whenever the design presents read data
    always @(negedge clk) begin
        if (rst_n && rd_valid) begin
            if (exp_q.size() == 0) begin
                n_cmp++;
                n_bad++;
                $display("FAIL R4: unexpected read data actual %02h expected none", rd_data);
            end else begin
                report(tag_q.pop_front(), rd_data, exp_q.pop_front());
            end
        end
    end

    task automatic send_byte(input logic [7:0] b);
        @(negedge clk);
        byte_valid = 1'b1;
        byte_in    = b;
        @(negedge clk);
        byte_valid = 1'b0;
    endtask

    task automatic cs_open();
        @(negedge clk);
        cs_n = 1'b0;
    endtask

    task automatic cs_close();
        @(negedge clk);
        cs_n  = 1'b1;
        m_idx = 0;
        @(negedge clk);
    endtask

    task automatic t_write(input logic [7:0] b);
        m_tbl[m_idx] = b;
        m_idx = (m_idx + 1) % 8;
        send_byte(b);
    endtask

    task automatic t_read(input string tag);
        exp_q.push_back(m_tbl[m_idx]);
        tag_q.push_back(tag);
        m_idx = (m_idx + 1) % 8;
        send_byte(8'h00);
    endtask

    task automatic check_pa(input string tag);
        for (int s = 0; s < 8; s++) begin
            pwr_sel = 3'(s);
            #1;
            report(tag, pa_setting, m_tbl[s]);
        end
    endtask

    task automatic drain(input string tag);
        @(negedge clk);
        @(negedge clk);
        n_cmp++;
        if (exp_q.size() != 0) begin
            n_bad++;
            $display("FAIL %s: %0d reads missing actual 0 expected %0d", tag, exp_q.size(), exp_q.size());
            exp_q.delete();
            tag_q.delete();
        end
    endtask

    initial begin
        #(CLK_PERIOD * 150000);
        n_bad++;
        $display("FAIL watchdog: actual hung expected finish");
        $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_cmp, n_bad);
        $finish;
    end

    initial begin
        for (int i = 0; i < 8; i++) m_tbl[i] = 8'h00;
        repeat (3) @(negedge clk);
        rst_n = 1'b1;
        @(negedge clk);

        // R1: reset state
        report("R1 rd_valid", {7'b0, rd_valid}, 8'h00);
        check_pa("R1 pa");

        // R2 R3: burst write fills all entries; R8: every select visible
        cs_open();
        send_byte(8'h7E);
        for (int i = 0; i < 8; i++) t_write(8'hA0 + 8'(i));
        cs_close();
        check_pa("R8 R3 burst write");

        // R4 R5: burst read wraps past entry 7
        cs_open();
        send_byte(8'hFE);
        for (int i = 0; i < 11; i++) t_read("R5 R4 burst read");
        cs_close();
        drain("R4");

        // R5: burst write of nine bytes overwrites entry 0
        cs_open();
        send_byte(8'h7E);
        for (int i = 0; i < 9; i++) t_write(8'h30 + 8'(i));
        cs_close();
        check_pa("R5 write wrap");

        // R7: single write then single read returns next entry
        cs_open();
        send_byte(8'h3E);
        t_write(8'h11);
        send_byte(8'hBE);
        t_read("R7 single read next entry");
        send_byte(8'h3E);
        t_write(8'h22);
        cs_close();
        drain("R7");
        check_pa("R7 single writes");

        // R6: chip select high resets index; strobes ignored while high
        cs_open();
        send_byte(8'h7E);
        t_write(8'h55);
        t_write(8'h66);
        cs_close();
        send_byte(8'h7E);
        send_byte(8'hEE);
        send_byte(8'hFE);
        send_byte(8'h00);
        cs_open();
        send_byte(8'h7E);
        t_write(8'h77);
        cs_close();
        drain("R6 no read while high");
        check_pa("R6 index reset");

        // R10: foreign header makes later bytes ignored
        cs_open();
        send_byte(8'h3D);
        send_byte(8'h99);
        send_byte(8'h7E);
        send_byte(8'h98);
        send_byte(8'hFE);
        send_byte(8'h00);
        cs_close();
        drain("R10 no read");
        check_pa("R10 ignored");

        // R2: single read header 0xBE then burst read header 0xFE
        cs_open();
        send_byte(8'hBE);
        t_read("R2 single read");
        send_byte(8'hFE);
        t_read("R2 burst read");
        t_read("R2 burst read");
        cs_close();
        drain("R2");

        // R9: sleep clears entries 1..7, keeps entry 0
        @(negedge clk);
        sleep_req = 1'b1;
        @(negedge clk);
        sleep_req = 1'b0;
        for (int i = 1; i < 8; i++) m_tbl[i] = 8'h00;
        check_pa("R9 sleep");
        cs_open();
        send_byte(8'hFE);
        for (int i = 0; i < 8; i++) t_read("R9 read after sleep");
        cs_close();
        drain("R9");

        $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_cmp, n_bad);
        $finish;
    end

endmodule